// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block decodes the command register of a NOR-style flash device. It watches bus write cycles, each one a write strobe qualified by chip enable together with an address and a data word. From them it recognises the multi-cycle command sequences: the two-cycle unlock prefix, autoselect entry, the four-cycle load of the burst configuration register, and the software reset.

From these sequences it tracks the read mode of the device. That mode is asynchronous array read, autoselect, reset pending after a configuration load, or an unknown state entered after a malformed sequence. The block also holds the burst configuration word.

A newly loaded configuration does not act at once: the block waits for a software reset before burst reads may be enabled. The configuration survives chip-enable deassertion, and only the hardware reset input clears it. Two status inputs restrict which writes are accepted: a program/erase error flag and a suspend flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises, `mode` is 0 (array read), `cfg_q` is 0 and `burst_en` is 0. Asserting `rst_n` low at any time clears a loaded configuration.
- R2: A write is a cycle with `we`=1 and `ce_n`=0. Commands use `wdata[7:0]` and `addr[10:0]`, and by default the address bits above bit 10 are not decoded. In array-read mode, the following four writes in order load `cfg_q` with `wdata[8:0]` of the last write and set `mode` to 2 (reset pending): AAh at 555h, then 55h at 2AAh, then D0h at 555h, then any data at 000h. The last write is captured even when its low byte is F0h.
- R3: The configuration fields are wait states `[3:0]`, burst mode `[5:4]`, clock edge `[6]`, ready polarity `[7]` and synchronous enable `[8]`. `burst_en` equals `cfg_q[8]` only while `mode` is 0. It is 0 while a reset is pending, and every write other than F0h is ignored in that mode.
- R4: In array-read mode, AAh at 555h, then 55h at 2AAh, then 90h at 555h sets `mode` to 1 (autoselect). In autoselect every write other than F0h is ignored.
- R5: In array-read mode, a write that is neither F0h nor the next expected cycle of a sequence sets `mode` to 3 (unknown). Mode 3 is sticky until an F0h write.
- R6: A write with F0h in `wdata[7:0]` at any address sets `mode` to 0 and discards a partial sequence, except when it is the fourth cycle of a configuration load. It leaves `cfg_q` unchanged.
- R7: While `ce_n` is 1, the block ignores writes: `mode` and `cfg_q` are unchanged.
- R8: While `err_flag` is 1, every write other than F0h is ignored. An F0h write is still accepted.
- R9: While `susp` is 1, D0h at 555h after the unlock prefix is rejected as out of sequence: `mode` becomes 3 and `cfg_q` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware / power-up reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we | input | 1 | Write strobe, one cycle per bus write |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data |
| err_flag | input | 1 | Program/erase error status |
| susp | input | 1 | Program or erase suspended |
| mode | output | 2 | 0 array read, 1 autoselect, 2 reset pending, 3 unknown |
| cfg_q | output | 9 | Burst configuration register |
| burst_en | output | 1 | Synchronous burst read enabled |

## Verification
The assertions check, on every cycle, several properties of the mode and configuration:
- the configuration changes only together with entry to reset pending;
- chip-enable-high and error-flag writes leave the state alone;
- the unknown and autoselect modes persist until F0h;
- F0h always returns the block to array read;
- a suspended configuration command falls into the unknown state.

Only the bench's scenarios can show the rest:
- the exact captured configuration value;
- the deferred effect of that value on `burst_en` until a software reset;
- the hardware reset clearing a loaded configuration;
- F0h captured as data on the fourth cycle.

Long random mixes of valid and broken sequences are compared against the bench's own model.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   localparam int CMD_AW = 11;
   localparam int CFG_W  = 9;

   localparam logic [CMD_AW-1:0] A_UNL1 = 11'h555;
   localparam logic [CMD_AW-1:0] A_UNL2 = 11'h2AA;
   localparam logic [CMD_AW-1:0] A_ZERO = 11'h000;

   localparam logic [7:0] D_UNL1  = 8'hAA;
   localparam logic [7:0] D_UNL2  = 8'h55;
   localparam logic [7:0] D_CFG   = 8'hD0;
   localparam logic [7:0] D_ASEL  = 8'h90;
   localparam logic [7:0] D_RESET = 8'hF0;

   typedef enum logic [1:0] {
      MODE_ARRAY   = 2'd0,
      MODE_AUTOSEL = 2'd1,
      MODE_RSTPEND = 2'd2,
      MODE_UNKNOWN = 2'd3
   } fcd_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_U1   = 2'd1,
      SQ_U2   = 2'd2,
      SQ_CFG  = 2'd3
   } fcd_seq_e;

   typedef struct packed {
      logic reset;
      logic unl1;
      logic unl2;
      logic cfg_cmd;
      logic asel;
      logic at_zero;
   } fcd_hit_t;

   typedef struct packed {
      logic       sync_en;
      logic       rdy_pol;
      logic       clk_edge;
      logic [1:0] burst_mode;
      logic [3:0] wait_states;
   } fcd_cfg_t;

endpackage

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
   import fcd_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int DATA_W           = 16,
   parameter bit FULL_ADDR_DECODE = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output fcd_hit_t          hits
);

   localparam int HI_W = ADDR_W - CMD_AW;

   initial begin
      assert (ADDR_W >= CMD_AW + 1) else $fatal(1, "ADDR_W must exceed %0d", CMD_AW);
      assert (DATA_W >= CFG_W + 1) else $fatal(1, "DATA_W must exceed %0d", CFG_W);
   end

   logic              upper_ok;
   logic [CMD_AW-1:0] a_lo;
   logic [7:0]        d_lo;
   logic              unused_data;

   assign a_lo = addr[CMD_AW-1:0];
   assign d_lo = wdata[7:0];
   assign unused_data = ^wdata[DATA_W-1:8];

   generate
      if (FULL_ADDR_DECODE) begin : g_full
         assign upper_ok = (addr[ADDR_W-1:CMD_AW] == {HI_W{1'b0}});
      end else begin : g_partial
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:CMD_AW];
         assign upper_ok  = 1'b1;
      end
   endgenerate

   always_comb begin
      hits.reset   = (d_lo == D_RESET);
      hits.unl1    = upper_ok && (a_lo == A_UNL1) && (d_lo == D_UNL1);
      hits.unl2    = upper_ok && (a_lo == A_UNL2) && (d_lo == D_UNL2);
      hits.cfg_cmd = upper_ok && (a_lo == A_UNL1) && (d_lo == D_CFG);
      hits.asel    = upper_ok && (a_lo == A_UNL1) && (d_lo == D_ASEL);
      hits.at_zero = upper_ok && (a_lo == A_ZERO);
   end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
   import fcd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr,
   input  fcd_hit_t  hits,
   input  logic      err_flag,
   input  logic      susp,
   output fcd_mode_e mode,
   output logic      cfg_load
);

   fcd_seq_e  seq, nxt_seq;
   fcd_mode_e nxt_mode;
   logic      live;

   assign live = (mode == MODE_ARRAY) && !err_flag;

   always_comb begin
      nxt_mode = mode;
      nxt_seq  = seq;
      cfg_load = 1'b0;
      if (wr) begin
         if (live && seq == SQ_CFG && hits.at_zero) begin
            cfg_load = 1'b1;
            nxt_mode = MODE_RSTPEND;
            nxt_seq  = SQ_IDLE;
         end else if (hits.reset) begin
            nxt_mode = MODE_ARRAY;
            nxt_seq  = SQ_IDLE;
         end else if (live) begin
            nxt_seq = SQ_IDLE;
            unique case (seq)
               SQ_IDLE: if (hits.unl1) nxt_seq = SQ_U1;
                        else nxt_mode = MODE_UNKNOWN;
               SQ_U1:   if (hits.unl2) nxt_seq = SQ_U2;
                        else nxt_mode = MODE_UNKNOWN;
               SQ_U2:   if (hits.asel) nxt_mode = MODE_AUTOSEL;
                        else if (hits.cfg_cmd && !susp) nxt_seq = SQ_CFG;
                        else nxt_mode = MODE_UNKNOWN;
               SQ_CFG:  nxt_mode = MODE_UNKNOWN;
               default: nxt_mode = MODE_UNKNOWN;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_ARRAY;
         seq  <= SQ_IDLE;
      end else begin
         mode <= nxt_mode;
         seq  <= nxt_seq;
      end
   end

   assert_unknown_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_UNKNOWN && !(wr && hits.reset)) |=> (mode == MODE_UNKNOWN));

   assert_autosel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AUTOSEL && !(wr && hits.reset)) |=> (mode == MODE_AUTOSEL));

   assert_reset_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hits.reset && seq != SQ_CFG) |=> (mode == MODE_ARRAY));

   assert_err_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && err_flag && !hits.reset) |=> $stable(mode));

   assert_susp_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && susp && live && seq == SQ_U2 && hits.cfg_cmd) |=> (mode == MODE_UNKNOWN));

endmodule

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg
   import fcd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] din,
   input  fcd_mode_e        mode,
   output fcd_cfg_t         cfg,
   output logic             burst_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg <= '0;
      else if (load) cfg <= fcd_cfg_t'(din);
   end

   assign burst_en = cfg.sync_en && (mode == MODE_ARRAY);

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int DATA_W           = 16,
   parameter bit FULL_ADDR_DECODE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              err_flag,
   input  logic              susp,
   output logic [1:0]        mode,
   output logic [CFG_W-1:0]  cfg_q,
   output logic              burst_en
);

   logic      wr;
   logic      cfg_load;
   fcd_hit_t  hits;
   fcd_mode_e mode_e;
   fcd_cfg_t  cfg;

   assign wr = we && !ce_n;

   fcd_cmd_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FULL_ADDR_DECODE(FULL_ADDR_DECODE)
   ) u_match (
      .addr(addr), .wdata(wdata), .hits(hits)
   );

   fcd_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr(wr), .hits(hits), .err_flag(err_flag),
      .susp(susp), .mode(mode_e), .cfg_load(cfg_load)
   );

   fcd_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .din(wdata[CFG_W-1:0]),
      .mode(mode_e), .cfg(cfg), .burst_en(burst_en)
   );

   assign mode  = mode_e;
   assign cfg_q = cfg;

   assert_cfg_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> (mode == MODE_RSTPEND && !burst_en));

   assert_ce_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> ($stable(mode) && $stable(cfg_q)));

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |-> (cfg_q == '0 && mode == MODE_ARRAY && !burst_en));

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          err_flag = 1'b0;
   logic          susp = 1'b0;
   logic [1:0]    mode;
   logic [8:0]    cfg_q;
   logic          burst_en;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int       m_mode = 0;
   int       m_seq = 0;
   bit [8:0] m_cfg = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we(we), .addr(addr), .wdata(wdata),
      .err_flag(err_flag), .susp(susp), .mode(mode), .cfg_q(cfg_q), .burst_en(burst_en)
   );

   task automatic check(string tag, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic bit exp_burst();
      return m_cfg[8] && (m_mode == 0);
   endfunction

   task automatic check_all(string tag);
      check({tag, " mode"}, int'(mode), m_mode);
      check({tag, " cfg"}, int'(cfg_q), int'(m_cfg));
      check({tag, " burst"}, int'(burst_en), int'(exp_burst()));
   endtask

   task automatic model(logic [AW-1:0] a, logic [DW-1:0] d);
      logic [10:0] al;
      logic [7:0]  dl;
      bit live;
      al = a[10:0];
      dl = d[7:0];
      if (ce_n) return;
      live = (m_mode == 0) && !err_flag;
      if (live && m_seq == 3 && al == 11'h000) begin
         m_cfg = d[8:0]; m_mode = 2; m_seq = 0;
      end else if (dl == 8'hF0) begin
         m_mode = 0; m_seq = 0;
      end else if (live) begin
         case (m_seq)
            0: if (al == 11'h555 && dl == 8'hAA) m_seq = 1; else m_mode = 3;
            1: if (al == 11'h2AA && dl == 8'h55) m_seq = 2; else begin m_mode = 3; m_seq = 0; end
            2: begin
               m_seq = 0;
               if (al == 11'h555 && dl == 8'h90) m_mode = 1;
               else if (al == 11'h555 && dl == 8'hD0 && !susp) m_seq = 3;
               else m_mode = 3;
            end
            default: begin m_mode = 3; m_seq = 0; end
         endcase
      end
   endtask

   task automatic bus_wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      model(a, d);
   endtask

   task automatic cfg_load(logic [8:0] v);
      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h02AA, 16'h0055);
      bus_wr(16'h0555, 16'h00D0);
      bus_wr(16'h0000, {7'd0, v});
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_mode = 0; m_seq = 0; m_cfg = '0;
      #1;
      check_all("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [AW-1:0] rnd_addr(logic [10:0] lo);
      logic [AW-1:0] r;
      r = AW'($urandom);
      r[10:0] = lo;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check_all("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      cfg_load(9'h1A5);
      check_all("R2 cfg loaded");
      check("R3 pending blocks burst", int'(burst_en), 0);
      bus_wr(16'h0555, 16'h00AA);
      check_all("R3 non-reset ignored");
      bus_wr(16'h1234, 16'h00F0);
      check_all("R3 reset enables burst");
      check("R3 burst on", int'(burst_en), 1);

      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h02AA, 16'h0055);
      bus_wr(16'h0555, 16'h0090);
      check_all("R4 autoselect entry");
      bus_wr(16'h0555, 16'h00AA);
      check_all("R4 autoselect hold");
      bus_wr(16'h0000, 16'h00F0);
      check_all("R4 autoselect exit");

      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h0123, 16'h0055);
      check_all("R5 bad unlock");
      bus_wr(16'h0555, 16'h00AA);
      check_all("R5 sticky");
      bus_wr(16'h0777, 16'h00F0);
      check_all("R6 reset from unknown");

      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h02AA, 16'h00F0);
      check_all("R6 partial discarded");
      bus_wr(16'h02AA, 16'h0055);
      check_all("R5 after discard");
      bus_wr(16'h0000, 16'h00F0);

      cfg_load(9'h0F0);
      check_all("R2 F0 captured as data");
      bus_wr(16'h0000, 16'h00F0);
      check_all("R6 cfg kept");

      ce_n = 1'b1;
      bus_wr(16'h0123, 16'h0033);
      check_all("R7 ce high ignored");
      ce_n = 1'b0;

      err_flag = 1'b1;
      bus_wr(16'h0123, 16'h0033);
      check_all("R8 err ignore");
      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h02AA, 16'h0055);
      bus_wr(16'h0555, 16'h0090);
      check_all("R8 err blocks autoselect");
      err_flag = 1'b0;

      susp = 1'b1;
      bus_wr(16'h0555, 16'h00AA);
      bus_wr(16'h02AA, 16'h0055);
      bus_wr(16'h0555, 16'h00D0);
      check_all("R9 suspend rejects cfg");
      susp = 1'b0;
      bus_wr(16'h0000, 16'h00F0);

      cfg_load(9'h155);
      bus_wr(16'h0000, 16'h00F0);
      hw_reset();
      check_all("R1 hw reset clears cfg");

      for (int i = 0; i < 1500; i++) begin
         int pick;
         ce_n     = ($urandom % 12) == 0;
         err_flag = ($urandom % 12) == 0;
         susp     = ($urandom % 10) == 0;
         pick = int'($urandom % 10);
         if (pick < 3) begin
            bus_wr(rnd_addr(11'h555), 16'h00AA);
            bus_wr(rnd_addr(11'h2AA), 16'h0055);
            bus_wr(rnd_addr(11'h555), 16'h00D0);
            bus_wr(rnd_addr(11'h000), DW'($urandom));
            check_all("R2 random cfg seq");
         end else if (pick == 3) begin
            bus_wr(rnd_addr(11'h555), 16'h00AA);
            bus_wr(rnd_addr(11'h2AA), 16'h0055);
            bus_wr(rnd_addr(11'h555), 16'h0090);
            check_all("R4 random asel seq");
         end else if (pick < 6) begin
            bus_wr(AW'($urandom), 16'h00F0);
            check_all("R6 random reset");
         end else begin
            bus_wr(AW'($urandom), DW'($urandom));
            check_all("R5 random write");
         end
      end
      ce_n = 1'b0; err_flag = 1'b0; susp = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule